// File: doc/BRIEF.md
# Serial Avionics Word Receiver with Bit Validation and Word Filtering

This block is the digital receive path of a two-wire, return-to-zero avionics data bus. Two comparator outputs reach it: one is high while the line sits at the ONE level and the other is high while it sits at the ZERO level. Both being low is a null. Both being high is an illegal sample. The block oversamples the pair at ten samples per bit time, with the sample period set by a rate select. It keeps a window of recent samples and recognises a data bit only when a level is followed by a null within the same bit time. It recognises the inter-word gap only when long runs of nulls fill the window.

Thirty-two recognised bits make a word. Two optional filters then apply: one compares word bits 9 and 10 against configured values, and the other looks up the 8-bit label in a 256-entry enable bitmap. A word that passes both filters is written into a 32-word receive queue. The host reads each queued word as two 16-bit halves and sees a data-ready flag while the queue holds anything. A 16-bit control register sets the rate and the filters. The host loads it with a write strobe and can always read it back.

Top module: `arx_receiver`

## Requirements
- R1: After synchronous reset, `data_ready` is low, the queue is empty, `cfg_rdata` is 0 and every label enable is cleared.
- R2: A cycle with `cfg_wr` high loads `cfg_wdata` into the control register, which appears on `cfg_rdata` from the next cycle and holds until the next write. Field positions: bit 0 selects the slow rate, bit 1 enables label filtering, bit 2 enables the bit-9/bit-10 check, bit 3 is the expected bit 9 and bit 4 is the expected bit 10.
- R3: Each full word received after a gap is queued in arrival order. The first bit on the line is stored in word bit 0 (word bit n-1 holds bit n). With `rd_sel`=0, `rd_data` shows word bits 15:0 of the oldest entry. With `rd_sel`=1 it shows bits 31:16. A cycle with `rd_en` and `rd_sel` both high removes that entry.
- R4: When control bit 2 is set, a word is discarded unless its word bit 8 equals control bit 3 and its word bit 9 equals control bit 4.
- R5: When control bit 1 is set, a word is discarded unless the bitmap entry addressed by word bits 7:0 is set. A cycle with `lbl_wr` high writes `lbl_set` into the entry at `lbl_addr`.
- R6: A word that sees a gap before its 32nd bit is dropped. The next full word after that gap is received normally.
- R7: A sample with both lines high aborts the word in progress. Bits are ignored until the next gap, and the next full word after that gap is received normally.
- R8: With control bit 0 set, the sample period is SLOW_MULT times the fast period, and words sent at the slow rate are received.
- R9: The queue holds at most DEPTH words. A word that arrives while the queue is full is dropped without disturbing the stored words. `data_ready` is high exactly while the queue is non-empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_one | input | 1 | Comparator output, high at the ONE level |
| line_zero | input | 1 | Comparator output, high at the ZERO level |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write value |
| cfg_rdata | output | 16 | Control register contents |
| lbl_wr | input | 1 | Label bitmap write strobe |
| lbl_addr | input | 8 | Label bitmap entry to write |
| lbl_set | input | 1 | Value written to the addressed entry |
| rd_sel | input | 1 | Half select: 0 low half, 1 high half |
| rd_en | input | 1 | Removes the oldest word when `rd_sel` is 1 |
| rd_data | output | 16 | Selected half of the oldest queued word |
| data_ready | output | 1 | Queue holds at least one word |

## Verification
The hardest states to reach from the ports are a full queue that receives one more word, and a word cut off in the middle by an illegal sample or by an early gap. The bench reaches them by building line waveforms sample by sample. It sends thirty-four words with no reads in between, sends a truncated word followed by a gap, and drives both lines high for a few samples in the middle of a word. After each of these it sends a clean word and checks that this word, and only this word, comes out in addition to what was already queued. Random words checked against a bench model of both filters cover the accept and discard decisions.

// File: rtl/arx_pkg.sv
package arx_pkg;

    localparam int WORD_BITS = 32;
    localparam int CFG_W     = 16;
    localparam int LABEL_W   = 8;

    typedef enum logic [1:0] {
        SYM_NULL = 2'd0,
        SYM_ONE  = 2'd1,
        SYM_ZERO = 2'd2,
        SYM_BAD  = 2'd3
    } sym_t;

    typedef struct packed {
        logic [10:0] spare;
        logic        want_b10;
        logic        want_b9;
        logic        b910_chk;
        logic        lbl_chk;
        logic        slow;
    } ctrl_t;

    function automatic sym_t classify(input logic one, input logic zero);
        case ({one, zero})
            2'b10:   return SYM_ONE;
            2'b01:   return SYM_ZERO;
            2'b00:   return SYM_NULL;
            default: return SYM_BAD;
        endcase
    endfunction

    function automatic logic word_ok(input ctrl_t c, input logic [WORD_BITS-1:0] w,
                                     input logic lbl_hit);
        logic ok;
        ok = 1'b1;
        if (c.b910_chk && (w[8] != c.want_b9 || w[9] != c.want_b10)) ok = 1'b0;
        if (c.lbl_chk && !lbl_hit) ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/arx_sampler.sv
module arx_sampler
    import arx_pkg::*;
#(
    parameter int FAST_DIV  = 4,
    parameter int SLOW_MULT = 8,
    parameter int SPB       = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic slow,
    input  logic line_one,
    input  logic line_zero,
    output logic bit_stb,
    output logic bit_val,
    output logic gap_det,
    output logic bad_det
);
    localparam int HALF     = SPB / 2;
    localparam int SLOW_DIV = FAST_DIV * SLOW_MULT;
    localparam int DW       = $clog2(SLOW_DIV + 1);

    logic [1:0]    one_s, zero_s;
    logic [DW-1:0] div_q, lim;
    logic          tick, eval_q;
    sym_t          win_q [SPB];

    assign lim  = slow ? DW'(SLOW_DIV - 1) : DW'(FAST_DIV - 1);
    assign tick = (div_q >= lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            one_s  <= '0;
            zero_s <= '0;
            div_q  <= '0;
            eval_q <= 1'b0;
            for (int i = 0; i < SPB; i++) win_q[i] <= SYM_BAD;
        end else begin
            one_s  <= {one_s[0], line_one};
            zero_s <= {zero_s[0], line_zero};
            div_q  <= tick ? '0 : div_q + 1'b1;
            eval_q <= tick;
            if (tick) begin
                win_q[0] <= classify(one_s[1], zero_s[1]);
                for (int i = 1; i < SPB; i++) win_q[i] <= win_q[i-1];
            end
        end
    end

    // index 0 is the newest sample; lower half newer, upper half older
    always_comb begin
        logic low_null, new_null, up_null, up_one, up_zero;
        low_null = 1'b1;
        for (int i = 0; i < HALF; i++)
            if (win_q[i] != SYM_NULL) low_null = 1'b0;
        new_null = 1'b1;
        up_null  = 1'b1;
        up_one   = 1'b1;
        up_zero  = 1'b1;
        for (int k = 0; k < 3; k++) begin
            if (win_q[k] != SYM_NULL)        new_null = 1'b0;
            if (win_q[HALF+k] != SYM_NULL)   up_null  = 1'b0;
            if (win_q[HALF+k] != SYM_ONE)    up_one   = 1'b0;
            if (win_q[HALF+k] != SYM_ZERO)   up_zero  = 1'b0;
        end
        bit_stb = eval_q && low_null && (up_one || up_zero);
        bit_val = up_one;
        gap_det = eval_q && new_null && up_null;
        bad_det = eval_q && (win_q[0] == SYM_BAD);
    end

endmodule

// File: rtl/arx_assembler.sv
module arx_assembler
    import arx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_stb,
    input  logic                 bit_val,
    input  logic                 gap_det,
    input  logic                 bad_det,
    output logic                 word_stb,
    output logic [WORD_BITS-1:0] word
);
    localparam int CW = $clog2(WORD_BITS);

    typedef enum logic {HUNT, LIVE} asm_st_t;

    asm_st_t      st_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= HUNT;
            cnt_q    <= '0;
            word     <= '0;
            word_stb <= 1'b0;
        end else begin
            word_stb <= 1'b0;
            if (bad_det) begin
                st_q  <= HUNT;
                cnt_q <= '0;
            end else if (gap_det) begin
                st_q  <= LIVE;
                cnt_q <= '0;
            end else if (bit_stb && st_q == LIVE) begin
                word[cnt_q] <= bit_val;
                if (cnt_q == CW'(WORD_BITS - 1)) begin
                    word_stb <= 1'b1;
                    st_q     <= HUNT;
                    cnt_q    <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/arx_fifo.sv
module arx_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] fill
);
    localparam int AW = $clog2(DEPTH);
    localparam int FW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic          do_push, do_pop;

    assign do_push = push && (fill != FW'(DEPTH));
    assign do_pop  = pop && (fill != '0);
    assign dout    = mem_q[rp_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q <= '0;
            rp_q <= '0;
            fill <= '0;
        end else begin
            if (do_push) begin
                mem_q[wp_q] <= din;
                wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            end
            if (do_pop)
                rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            fill <= fill + FW'(do_push) - FW'(do_pop);
        end
    end

endmodule

// File: rtl/arx_receiver.sv
module arx_receiver
    import arx_pkg::*;
#(
    parameter int FAST_DIV  = 4,
    parameter int SLOW_MULT = 8,
    parameter int DEPTH     = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_one,
    input  logic               line_zero,
    input  logic               cfg_wr,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_rdata,
    input  logic               lbl_wr,
    input  logic [LABEL_W-1:0] lbl_addr,
    input  logic               lbl_set,
    input  logic               rd_sel,
    input  logic               rd_en,
    output logic [15:0]        rd_data,
    output logic               data_ready
);
    localparam int LABELS = 1 << LABEL_W;
    localparam int FW     = $clog2(DEPTH + 1);

    ctrl_t                 cfg_q;
    logic [LABELS-1:0]     lbl_map_q;
    logic                  bit_stb, bit_val, gap_det, bad_det;
    logic                  word_stb, push, pop;
    logic [WORD_BITS-1:0]  word, head;
    logic [FW-1:0]         fill_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            lbl_map_q <= '0;
        end else begin
            if (cfg_wr) cfg_q <= ctrl_t'(cfg_wdata);
            if (lbl_wr) lbl_map_q[lbl_addr] <= lbl_set;
        end
    end

    assign cfg_rdata = cfg_q;

    arx_sampler #(.FAST_DIV(FAST_DIV), .SLOW_MULT(SLOW_MULT), .SPB(10)) smp_i (
        .clk, .rst, .slow(cfg_q.slow), .line_one, .line_zero,
        .bit_stb, .bit_val, .gap_det, .bad_det
    );

    arx_assembler asm_i (
        .clk, .rst, .bit_stb, .bit_val, .gap_det, .bad_det, .word_stb, .word
    );

    assign push = word_stb && word_ok(cfg_q, word, lbl_map_q[word[LABEL_W-1:0]]);
    assign pop  = rd_en && rd_sel;

    arx_fifo #(.W(WORD_BITS), .DEPTH(DEPTH)) fifo_i (
        .clk, .rst, .push, .din(word), .pop, .dout(head), .fill(fill_cnt)
    );

    assign data_ready = (fill_cnt != '0);
    assign rd_data    = rd_sel ? head[31:16] : head[15:0];

endmodule

// File: rtl/arx_receiver_chk.sv
module arx_receiver_chk #(
    parameter int DEPTH = 32
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       cfg_wr,
    input logic [15:0]                cfg_wdata,
    input logic [15:0]                cfg_rdata,
    input logic                       rd_en,
    input logic                       rd_sel,
    input logic                       data_ready,
    input logic [$clog2(DEPTH+1)-1:0] fill
);
    a_r1_reset_empty: assert property (@(posedge clk) rst |=> (!data_ready && cfg_rdata == '0));

    a_r2_cfg_load: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> cfg_rdata == $past(cfg_wdata));

    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> $stable(cfg_rdata));

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        fill <= ($clog2(DEPTH+1))'(DEPTH));

    a_r3_pop_only_on_read: assert property (@(posedge clk) disable iff (rst)
        (fill < $past(fill)) |-> $past(rd_en && rd_sel));

    a_r9_full_holds: assert property (@(posedge clk) disable iff (rst)
        (fill == ($clog2(DEPTH+1))'(DEPTH) && !(rd_en && rd_sel)) |=> (fill == ($clog2(DEPTH+1))'(DEPTH)));
endmodule

bind arx_receiver arx_receiver_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rd_en(rd_en), .rd_sel(rd_sel), .data_ready(data_ready), .fill(fill_cnt)
);

// File: tb/arx_receiver_tb_top.sv
module arx_receiver_tb_top;
    localparam int FAST = 4;
    localparam int SLOWM = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic line_one = 1'b0, line_zero = 1'b0;
    logic cfg_wr = 1'b0, lbl_wr = 1'b0, lbl_set = 1'b0, rd_sel = 1'b0, rd_en = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [7:0]  lbl_addr = '0;
    logic [15:0] cfg_rdata, rd_data;
    logic        data_ready;

    int n_chk = 0, n_fail = 0, cur_div = FAST;
    logic [15:0]  tcfg = '0;
    logic [255:0] tmap = '0;
    logic [31:0]  exp_q [$];

    always #4 clk = ~clk;

    arx_receiver #(.FAST_DIV(FAST), .SLOW_MULT(SLOWM), .DEPTH(32)) dut_i (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit tb_accept(input logic [31:0] w);
        bit ok = 1;
        if (tcfg[2] && (w[8] != tcfg[3] || w[9] != tcfg[4])) ok = 0;
        if (tcfg[1] && !tmap[w[7:0]]) ok = 0;
        return ok;
    endfunction

    task automatic drive(input logic o, input logic z, input int nsamp);
        @(negedge clk);
        line_one = o; line_zero = z;
        repeat (nsamp * cur_div - 1) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        drive(b, ~b, 5);
        drive(1'b0, 1'b0, 5);
    endtask

    task automatic send_gap();
        drive(1'b0, 1'b0, 60);
    endtask

    task automatic send_word(input logic [31:0] w, input int nbits);
        for (int i = 0; i < nbits; i++) send_bit(w[i]);
        send_gap();
    endtask

    task automatic send_model(input logic [31:0] w);
        send_word(w, 32);
        if (tb_accept(w) && exp_q.size() < 32) exp_q.push_back(w);
    endtask

    task automatic set_cfg(input logic [15:0] v);
        @(negedge clk); cfg_wdata = v; cfg_wr = 1'b1;
        @(negedge clk); cfg_wr = 1'b0;
        tcfg = v;
        cur_div = v[0] ? FAST * SLOWM : FAST;
    endtask

    task automatic set_label(input logic [7:0] a, input logic v);
        @(negedge clk); lbl_addr = a; lbl_set = v; lbl_wr = 1'b1;
        @(negedge clk); lbl_wr = 1'b0;
        tmap[a] = v;
    endtask

    task automatic pop_word(output logic [31:0] w);
        @(negedge clk);
        rd_sel = 1'b0;
        #1 w[15:0] = rd_data;
        rd_sel = 1'b1;
        #1 w[31:16] = rd_data;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        rd_sel = 1'b0;
    endtask

    task automatic drain(input string req);
        logic [31:0] got, want;
        while (exp_q.size() > 0) begin
            want = exp_q.pop_front();
            chk(data_ready === 1'b1, "R9 ready while queued", {31'd0, data_ready}, 32'd1);
            pop_word(got);
            chk(got === want, req, got, want);
        end
        @(negedge clk);
        chk(data_ready === 1'b0, {req, " queue empty after drain (R9)"}, {31'd0, data_ready}, 32'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] w;
        void'($urandom(32'd4368));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(data_ready === 1'b0, "R1 ready after reset", {31'd0, data_ready}, 32'd0);
        chk(cfg_rdata === 16'h0, "R1 cfg after reset", {16'd0, cfg_rdata}, 32'd0);

        // R2 control register write and read back
        set_cfg(16'hA5E0);
        chk(cfg_rdata === 16'hA5E0, "R2 cfg readback", {16'd0, cfg_rdata}, 32'h0000A5E0);
        @(negedge clk);
        chk(cfg_rdata === 16'hA5E0, "R2 cfg holds", {16'd0, cfg_rdata}, 32'h0000A5E0);
        set_cfg(16'h0000);

        // R3 plain reception, random words plus fixed patterns
        send_gap();
        send_model(32'h0000_0001);
        send_model(32'h8000_0000);
        send_model(32'hFFFF_FFFF);
        for (int i = 0; i < 9; i++) send_model($urandom);
        drain("R3 word order and halves");

        // R4 bit 9/10 check: enabled, expect bit9=1 bit10=0
        set_cfg(16'h000C);
        send_gap();
        for (int i = 0; i < 10; i++) begin
            w = $urandom;
            if (i % 3 == 0) w[9:8] = 2'b01;
            send_model(w);
        end
        send_model(32'h0000_0100);
        send_model(32'h0000_0200);
        drain("R4 bit9/bit10 filter");

        // R5 label filter
        set_label(8'h21, 1'b1);
        set_label(8'hC4, 1'b1);
        set_label(8'h07, 1'b1);
        set_cfg(16'h0002);
        send_gap();
        for (int i = 0; i < 10; i++) begin
            w = $urandom;
            if (i % 2 == 0) w[7:0] = (i % 4 == 0) ? 8'h21 : 8'hC4;
            send_model(w);
        end
        set_label(8'h21, 1'b0);
        send_model(32'h1234_5621);
        send_model(32'h1234_5607);
        drain("R5 label bitmap filter");

        // R6 short word then gap is dropped
        set_cfg(16'h0000);
        send_gap();
        send_word(32'hDEAD_BEEF, 20);
        send_model(32'h0BAD_F00D);
        drain("R6 short word dropped");

        // R7 illegal sample mid word
        for (int i = 0; i < 10; i++) send_bit(1'b1);
        drive(1'b1, 1'b1, 3);
        drive(1'b0, 1'b0, 2);
        for (int i = 0; i < 22; i++) send_bit(1'b0);
        @(negedge clk);
        chk(data_ready === 1'b0, "R7 aborted word not queued", {31'd0, data_ready}, 32'd0);
        send_gap();
        send_model(32'h5A5A_C3C3);
        drain("R7 recovery after illegal sample");

        // R9 overflow: 34 words, only first 32 kept
        for (int i = 0; i < 34; i++) send_model($urandom);
        chk(exp_q.size() == 32, "R9 model holds 32", exp_q.size(), 32);
        drain("R9 full queue keeps first words");

        // R8 slow rate
        set_cfg(16'h0001);
        send_gap();
        send_model(32'hC001_D00D);
        drain("R8 slow rate word");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule